// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

This block is a first-in first-out buffer of 9-bit words, 4096 entries deep, whose write port and read port run from two unrelated clocks. Write pointers and read pointers cross between the two clock domains as Gray code. The full and almost-full flags are registered on the write clock. The empty and almost-empty flags are registered on the read clock. All four flags are active low.

The almost-empty threshold and the almost-full threshold are each held in a 12-bit offset register. One control input has two roles, and which role it takes is fixed by its level while reset is held. If it is high, it is a second write enable. If it is low, it becomes an active-low load strobe. While that strobe is asserted, the write port loads the offset registers and the read port reads them back, each port stepping through the four offset fields with its own pointer. A dual-channel arrangement is two instances of this block. The output-enable input gates the read data, and a valid output models a pad that is driven.

Top module: `prog_flag_fifo`

## Requirements
- R1: When reset ends, `empty_n` and `almost_empty_n` are low, `full_n` and `almost_full_n` are high, and the FIFO holds no words. Reset is synchronous and active low. It must be held across at least two edges of each clock.
- R2: A rising `wclk` stores `din` only when `wen1_n` is 0, `wen2_ld` is 1 and `full_n` is 1. Any write attempted under other conditions, including while the FIFO is full, leaves the contents unchanged.
- R3: The level of `wen2_ld` during reset selects the mode: 1 selects two-enable mode and 0 selects offset mode. In offset mode, `wen2_ld` = 1 with `wen1_n` = 0 still writes the FIFO. In two-enable mode, `wen2_ld` = 0 never touches the offset registers.
- R4: In offset mode, a rising `wclk` with `wen1_n` = 0 and `wen2_ld` = 0 writes `din` into the next offset field and does not write the FIFO. The four fields are taken in a fixed order that wraps after the fourth: empty offset bits 7:0 from `din[7:0]`, then empty offset bits 11:8 from `din[3:0]`, then full offset bits 7:0, then full offset bits 11:8.
- R5: In offset mode, a rising `rclk` with `ren1_n` = 0, `ren2_n` = 0 and `wen2_ld` = 0 puts the next offset field, zero-extended, on the read data. It follows the same field order through a read-side pointer of its own and does not pop a word.
- R6: A rising `rclk` with both read enables at 0, not empty, and no offset read pops the oldest word. That word appears on `dout` after the same edge.
- R7: `empty_n` is low exactly when the read side sees a fill level of zero.
- R8: `full_n` is low when the write side sees 4096 stored words.
- R9: `almost_empty_n` is low when the fill level is less than or equal to the empty offset.
- R10: `almost_full_n` is low when the free space is less than or equal to the full offset.
- R11: Reset sets both offsets to 7.
- R12: When `oe_n` is 1, `dout_valid` is 0 and `dout` is all zeros. When `oe_n` is 0, `dout_valid` is 1 and `dout` shows the last read data.
- R13: Pointer codes crossing the clock domains change by at most one bit per edge. `empty_n` does not rise before the second read edge after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rst_n | input | 1 | Synchronous active-low reset, seen by both clocks |
| din | input | 9 | Write data, also the offset load value |
| wen1_n | input | 1 | Primary write enable, active low |
| wen2_ld | input | 1 | Second write enable or active-low offset load strobe, chosen at reset |
| full_n | output | 1 | Low when full, on the write clock |
| almost_full_n | output | 1 | Low when free space is at or below the full offset |
| rclk | input | 1 | Read-side clock |
| ren1_n | input | 1 | Read enable one, active low |
| ren2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Read data, zero while the output is disabled |
| dout_valid | output | 1 | High while the read data would drive the bus |
| empty_n | output | 1 | Low when empty, on the read clock |
| almost_empty_n | output | 1 | Low when fill level is at or below the empty offset |

## Verification
The hardest states to reach are the almost-full and full boundaries, which need more than four thousand stored words. The stimulus gets there with long bursts of back-to-back writes, checks the almost-full edge one word on either side of the threshold, offers one extra word once the FIFO is full, and then drains all 4096 words in order. Offset mode is reached through a second reset with the dual-role input held low. There the offset registers are read back both before and after loading, and words sit in the FIFO throughout, so any stray write into the FIFO or stray pop becomes visible.

// File: rtl/pfifo_pkg.sv
package pfifo_pkg;

    typedef enum logic {
        MODE_OFS_LOAD = 1'b0,
        MODE_TWO_WE   = 1'b1
    } we_mode_e;

    typedef enum logic [1:0] {
        SLOT_AE_LO = 2'd0,
        SLOT_AE_HI = 2'd1,
        SLOT_AF_LO = 2'd2,
        SLOT_AF_HI = 2'd3
    } ofs_slot_e;

    function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pfifo_sync2.sv
module pfifo_sync2 #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q, stage2_q;
    logic [W-1:0] stage1_d, stage2_d;

    always_comb begin
        stage1_d = d;
        stage2_d = stage1_q;
        if (!rst_n) begin
            stage1_d = '0;
            stage2_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        stage1_q <= stage1_d;
        stage2_q <= stage2_d;
    end

    assign q = stage2_q;
endmodule

// File: rtl/pfifo_ram.sv
module pfifo_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 12
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pfifo_wr_side.sv
module pfifo_wr_side
    import pfifo_pkg::*;
#(
    parameter int DATA_W    = 9,
    parameter int ADDR_W    = 12,
    parameter int OFS_RESET = 7
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    input  logic [ADDR_W:0]   rgray_sync,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full_n,
    output logic              almost_full_n,
    output logic [ADDR_W-1:0] ae_ofs,
    output logic [ADDR_W-1:0] af_ofs
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int HI_W  = ADDR_W - 8;
    localparam logic [PTR_W-1:0]  DEPTH    = {1'b1, {ADDR_W{1'b0}}};
    localparam logic [ADDR_W-1:0] OFS_INIT = ADDR_W'(OFS_RESET);

    typedef struct packed {
        we_mode_e          mode;
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              full_n;
        logic              afull_n;
        ofs_slot_e         slot;
        logic [ADDR_W-1:0] ae_ofs;
        logic [ADDR_W-1:0] af_ofs;
    } wr_state_t;

    wr_state_t        st_d, st_q;
    logic             push;
    logic             load_hit;
    logic [PTR_W-1:0] nbin, rbin, used, free;

    always_comb begin
        st_d     = st_q;
        load_hit = (st_q.mode == MODE_OFS_LOAD) && !wen2_ld && !wen1_n;
        push     = !wen1_n && wen2_ld && st_q.full_n;
        nbin     = st_q.bin + PTR_W'(push);
        rbin     = PTR_W'(gray_to_bin(32'(rgray_sync)));
        used     = nbin - rbin;
        free     = DEPTH - used;

        st_d.bin     = nbin;
        st_d.gray    = nbin ^ (nbin >> 1);
        st_d.full_n  = (used != DEPTH);
        st_d.afull_n = (free > {1'b0, st_q.af_ofs});

        if (load_hit) begin
            case (st_q.slot)
                SLOT_AE_LO: st_d.ae_ofs[7:0]        = din[7:0];
                SLOT_AE_HI: st_d.ae_ofs[ADDR_W-1:8] = din[HI_W-1:0];
                SLOT_AF_LO: st_d.af_ofs[7:0]        = din[7:0];
                SLOT_AF_HI: st_d.af_ofs[ADDR_W-1:8] = din[HI_W-1:0];
                default:    st_d.ae_ofs             = st_q.ae_ofs;
            endcase
            st_d.slot = ofs_slot_e'(st_q.slot + 2'd1);
        end

        if (!rst_n) begin
            st_d.mode    = we_mode_e'(wen2_ld);
            st_d.bin     = '0;
            st_d.gray    = '0;
            st_d.full_n  = 1'b1;
            st_d.afull_n = 1'b1;
            st_d.slot    = SLOT_AE_LO;
            st_d.ae_ofs  = OFS_INIT;
            st_d.af_ofs  = OFS_INIT;
            push         = 1'b0;
        end
    end

    always_ff @(posedge wclk) begin
        st_q <= st_d;
    end

    assign mem_we        = push;
    assign mem_waddr     = st_q.bin[ADDR_W-1:0];
    assign wgray         = st_q.gray;
    assign full_n        = st_q.full_n;
    assign almost_full_n = st_q.afull_n;
    assign ae_ofs        = st_q.ae_ofs;
    assign af_ofs        = st_q.af_ofs;
endmodule

// File: rtl/pfifo_rd_side.sv
module pfifo_rd_side
    import pfifo_pkg::*;
#(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 12
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              wen2_ld,
    input  logic [ADDR_W:0]   wgray_sync,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic [ADDR_W-1:0] af_ofs,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty_n,
    output logic              almost_empty_n,
    output logic [DATA_W-1:0] rdata
);
    localparam int PTR_W = ADDR_W + 1;

    typedef struct packed {
        we_mode_e          mode;
        logic [PTR_W-1:0]  bin;
        logic [PTR_W-1:0]  gray;
        logic              empty_n;
        logic              aempty_n;
        ofs_slot_e         slot;
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t        st_d, st_q;
    logic             rd_req, load_sel, pop;
    logic [PTR_W-1:0] nbin, wbin, used;

    always_comb begin
        st_d     = st_q;
        rd_req   = !ren1_n && !ren2_n;
        load_sel = (st_q.mode == MODE_OFS_LOAD) && !wen2_ld;
        pop      = rd_req && !load_sel && st_q.empty_n;
        nbin     = st_q.bin + PTR_W'(pop);
        wbin     = PTR_W'(gray_to_bin(32'(wgray_sync)));
        used     = wbin - nbin;

        st_d.bin      = nbin;
        st_d.gray     = nbin ^ (nbin >> 1);
        st_d.empty_n  = (used != '0);
        st_d.aempty_n = (used > {1'b0, ae_ofs});

        if (pop) begin
            st_d.data = mem_rdata;
        end
        if (rd_req && load_sel) begin
            case (st_q.slot)
                SLOT_AE_LO: st_d.data = DATA_W'(ae_ofs[7:0]);
                SLOT_AE_HI: st_d.data = DATA_W'(ae_ofs[ADDR_W-1:8]);
                SLOT_AF_LO: st_d.data = DATA_W'(af_ofs[7:0]);
                SLOT_AF_HI: st_d.data = DATA_W'(af_ofs[ADDR_W-1:8]);
                default:    st_d.data = st_q.data;
            endcase
            st_d.slot = ofs_slot_e'(st_q.slot + 2'd1);
        end

        if (!rst_n) begin
            st_d.mode     = we_mode_e'(wen2_ld);
            st_d.bin      = '0;
            st_d.gray     = '0;
            st_d.empty_n  = 1'b0;
            st_d.aempty_n = 1'b0;
            st_d.slot     = SLOT_AE_LO;
            st_d.data     = '0;
        end
    end

    always_ff @(posedge rclk) begin
        st_q <= st_d;
    end

    assign mem_raddr      = st_q.bin[ADDR_W-1:0];
    assign rgray          = st_q.gray;
    assign empty_n        = st_q.empty_n;
    assign almost_empty_n = st_q.aempty_n;
    assign rdata          = st_q.data;
endmodule

// File: rtl/prog_flag_fifo.sv
module prog_flag_fifo #(
    parameter int DATA_W    = 9,
    parameter int ADDR_W    = 12,
    parameter int OFS_RESET = 7
) (
    input  logic              wclk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wen1_n,
    input  logic              wen2_ld,
    output logic              full_n,
    output logic              almost_full_n,
    input  logic              rclk,
    input  logic              ren1_n,
    input  logic              ren2_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr, mem_raddr;
    logic [DATA_W-1:0] mem_rdata, rdata;
    logic [PTR_W-1:0]  wgray, rgray, wgray_sync, rgray_sync;
    logic [ADDR_W-1:0] ae_ofs, af_ofs;

    pfifo_wr_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OFS_RESET(OFS_RESET)) u_wr (
        .wclk          (wclk),
        .rst_n         (rst_n),
        .din           (din),
        .wen1_n        (wen1_n),
        .wen2_ld       (wen2_ld),
        .rgray_sync    (rgray_sync),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .wgray         (wgray),
        .full_n        (full_n),
        .almost_full_n (almost_full_n),
        .ae_ofs        (ae_ofs),
        .af_ofs        (af_ofs)
    );

    pfifo_sync2 #(.W(PTR_W)) u_r2w (
        .clk   (wclk),
        .rst_n (rst_n),
        .d     (rgray),
        .q     (rgray_sync)
    );

    pfifo_sync2 #(.W(PTR_W)) u_w2r (
        .clk   (rclk),
        .rst_n (rst_n),
        .d     (wgray),
        .q     (wgray_sync)
    );

    pfifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (din),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    pfifo_rd_side #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk           (rclk),
        .rst_n          (rst_n),
        .ren1_n         (ren1_n),
        .ren2_n         (ren2_n),
        .wen2_ld        (wen2_ld),
        .wgray_sync     (wgray_sync),
        .mem_rdata      (mem_rdata),
        .ae_ofs         (ae_ofs),
        .af_ofs         (af_ofs),
        .mem_raddr      (mem_raddr),
        .rgray          (rgray),
        .empty_n        (empty_n),
        .almost_empty_n (almost_empty_n),
        .rdata          (rdata)
    );

    assign dout       = oe_n ? '0 : rdata;
    assign dout_valid = !oe_n;
endmodule

// File: rtl/prog_flag_fifo_chk.sv
module prog_flag_fifo_chk #(
    parameter int PTR_W = 13
) (
    input logic             wclk,
    input logic             rclk,
    input logic             rst_n,
    input logic             full_n,
    input logic             almost_full_n,
    input logic             empty_n,
    input logic             almost_empty_n,
    input logic [PTR_W-1:0] wgray,
    input logic [PTR_W-1:0] rgray
);
    assert_push_stops_when_full_R2: assert property (
        @(posedge wclk) disable iff (!rst_n) !full_n |=> $stable(wgray));

    assert_pop_stops_when_empty_R6: assert property (
        @(posedge rclk) disable iff (!rst_n) !empty_n |=> $stable(rgray));

    assert_wgray_single_step_R13: assert property (
        @(posedge wclk) disable iff (!rst_n) $countones(wgray ^ $past(wgray)) <= 1);

    assert_rgray_single_step_R13: assert property (
        @(posedge rclk) disable iff (!rst_n) $countones(rgray ^ $past(rgray)) <= 1);

    assert_empty_implies_aempty_R9: assert property (
        @(posedge rclk) disable iff (!rst_n) !empty_n |-> !almost_empty_n);

    assert_full_implies_afull_R10: assert property (
        @(posedge wclk) disable iff (!rst_n) !full_n |-> !almost_full_n);
endmodule

bind prog_flag_fifo prog_flag_fifo_chk #(.PTR_W(ADDR_W + 1)) u_chk (
    .wclk           (wclk),
    .rclk           (rclk),
    .rst_n          (rst_n),
    .full_n         (full_n),
    .almost_full_n  (almost_full_n),
    .empty_n        (empty_n),
    .almost_empty_n (almost_empty_n),
    .wgray          (wgray),
    .rgray          (rgray)
);

// File: tb/prog_flag_fifo_test.sv
module prog_flag_fifo_test;
    logic       wclk = 1'b0;
    logic       rclk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] din = '0;
    logic       wen1_n = 1'b1;
    logic       wen2_ld = 1'b1;
    logic       ren1_n = 1'b1;
    logic       ren2_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       full_n, almost_full_n, empty_n, almost_empty_n, dout_valid;
    logic [8:0] dout;

    int n_checks = 0;
    int n_fails  = 0;

    prog_flag_fifo uut (
        .wclk(wclk), .rst_n(rst_n), .din(din), .wen1_n(wen1_n), .wen2_ld(wen2_ld),
        .full_n(full_n), .almost_full_n(almost_full_n), .rclk(rclk),
        .ren1_n(ren1_n), .ren2_n(ren2_n), .oe_n(oe_n), .dout(dout),
        .dout_valid(dout_valid), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    always #5 wclk = ~wclk;
    initial begin
        #3;
        forever #5 rclk = ~rclk;
    end

    // bit 9: 1 = push the data, 0 = pop and expect the data
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 9'h155}, {1'b1, 9'h0AA}, {1'b0, 9'h155}, {1'b1, 9'h1FF},
        {1'b0, 9'h0AA}, {1'b0, 9'h1FF}, {1'b1, 9'h000}, {1'b0, 9'h000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    task automatic apply_reset(input logic mode);
        rst_n = 1'b0; wen2_ld = mode; wen1_n = 1'b1; ren1_n = 1'b1; ren2_n = 1'b1;
        repeat (4) @(negedge wclk);
        rst_n = 1'b1; wen2_ld = 1'b1;
        repeat (2) @(negedge rclk);
    endtask

    task automatic push(input logic [8:0] d);
        @(negedge wclk); din = d; wen1_n = 1'b0; wen2_ld = 1'b1;
        @(negedge wclk); wen1_n = 1'b1;
    endtask

    task automatic pop(output logic [8:0] v);
        @(negedge rclk); ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1; v = dout;
    endtask

    task automatic ofs_load(input logic [8:0] d);
        @(negedge wclk); din = d; wen2_ld = 1'b0; wen1_n = 1'b0;
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
    endtask

    task automatic ofs_read(output logic [8:0] v);
        @(negedge rclk); wen2_ld = 1'b0; ren1_n = 1'b0; ren2_n = 1'b0;
        @(negedge rclk); ren1_n = 1'b1; ren2_n = 1'b1; wen2_ld = 1'b1; v = dout;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    initial begin
        #1_000_000;
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        logic [8:0] v;
        int mism;

        // two-enable mode
        apply_reset(1'b1);
        chk("R1 empty_n", 32'(empty_n), 32'd0);
        chk("R1 almost_empty_n", 32'(almost_empty_n), 32'd0);
        chk("R1 full_n", 32'(full_n), 32'd1);
        chk("R1 almost_full_n", 32'(almost_full_n), 32'd1);

        // R13: empty_n must not rise on the first read edge after a write
        push(9'h0C3);
        @(negedge rclk);
        chk("R13 early empty_n", 32'(empty_n), 32'd0);
        settle();
        chk("R7 empty_n after write", 32'(empty_n), 32'd1);
        pop(v);
        chk("R6 first word", 32'(v), 32'h0C3);
        settle();
        chk("R7 empty_n after drain", 32'(empty_n), 32'd0);

        // R12 output enable
        oe_n = 1'b1; #1;
        chk("R12 valid off", 32'(dout_valid), 32'd0);
        chk("R12 dout zero", 32'(dout), 32'd0);
        oe_n = 1'b0; #1;
        chk("R12 valid on", 32'(dout_valid), 32'd1);
        chk("R12 dout shows data", 32'(dout), 32'h0C3);

        // vector table
        foreach (VEC[i]) begin
            if (VEC[i][9]) begin
                push(VEC[i][8:0]);
            end else begin
                pop(v);
                chk("R6 vector pop", 32'(v), 32'(VEC[i][8:0]));
            end
            settle();
        end
        chk("R7 empty after vectors", 32'(empty_n), 32'd0);

        // R2 / R3: wen2 low in two-enable mode blocks writes and leaves offsets alone
        @(negedge wclk); din = 9'h001; wen1_n = 1'b0; wen2_ld = 1'b0;
        @(negedge wclk); wen1_n = 1'b1; wen2_ld = 1'b1;
        @(negedge wclk); din = 9'h002; wen1_n = 1'b1; wen2_ld = 1'b1;
        settle();
        chk("R2 blocked write", 32'(empty_n), 32'd0);
        for (int i = 0; i < 7; i++) push(9'(i + 16));
        settle();
        chk("R9 R11 fill 7 aempty", 32'(almost_empty_n), 32'd0);
        push(9'h017);
        settle();
        chk("R9 R3 fill 8 not aempty", 32'(almost_empty_n), 32'd1);
        mism = 0;
        for (int i = 0; i < 8; i++) begin
            pop(v);
            if (v !== 9'(i + 16)) mism++;
        end
        chk("R6 drain order", 32'(mism), 32'd0);

        // bulk fill toward full
        for (int i = 0; i < 4088; i++) push(9'(i));
        settle();
        chk("R10 free 8 not afull", 32'(almost_full_n), 32'd1);
        push(9'(4088));
        settle();
        chk("R10 free 7 afull", 32'(almost_full_n), 32'd0);
        chk("R8 not yet full", 32'(full_n), 32'd1);
        for (int i = 4089; i < 4096; i++) push(9'(i));
        settle();
        chk("R8 full", 32'(full_n), 32'd0);
        push(9'h1AA);
        settle();
        mism = 0;
        for (int i = 0; i < 4096; i++) begin
            pop(v);
            if (v !== 9'(i)) mism++;
        end
        chk("R6 bulk order", 32'(mism), 32'd0);
        settle();
        chk("R2 extra word dropped", 32'(empty_n), 32'd0);
        chk("R8 full released", 32'(full_n), 32'd1);

        // offset mode
        apply_reset(1'b0);
        chk("R3 offset mode reset empty", 32'(empty_n), 32'd0);
        ofs_read(v); chk("R11 R5 ae lo", 32'(v), 32'd7);
        ofs_read(v); chk("R11 R5 ae hi", 32'(v), 32'd0);
        ofs_read(v); chk("R11 R5 af lo", 32'(v), 32'd7);
        ofs_read(v); chk("R11 R5 af hi", 32'(v), 32'd0);
        push(9'h111);
        settle();
        chk("R3 write in offset mode", 32'(empty_n), 32'd1);
        ofs_load(9'h002); ofs_load(9'h000); ofs_load(9'h005); ofs_load(9'h001);
        settle();
        ofs_read(v); chk("R4 ae lo", 32'(v), 32'h002);
        ofs_read(v); chk("R4 ae hi", 32'(v), 32'h000);
        ofs_read(v); chk("R4 af lo", 32'(v), 32'h005);
        ofs_read(v); chk("R4 af hi", 32'(v), 32'h001);
        settle();
        chk("R9 fill 1 vs offset 2", 32'(almost_empty_n), 32'd0);
        push(9'h122); push(9'h133);
        settle();
        chk("R9 fill 3 vs offset 2", 32'(almost_empty_n), 32'd1);
        ofs_read(v); chk("R5 read wraps", 32'(v), 32'h002);
        mism = 0;
        pop(v); if (v !== 9'h111) mism++;
        pop(v); if (v !== 9'h122) mism++;
        pop(v); if (v !== 9'h133) mism++;
        chk("R4 R5 fifo untouched by offset access", 32'(mism), 32'd0);
        settle();
        chk("R4 no stray words", 32'(empty_n), 32'd0);

        summary();
        $finish;
    end
endmodule